// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the digital frequency-offset code that steers a PLL's controlled oscillator through a current DAC, so that the output clock sweeps slowly across a narrow band and its radiated energy is spread. It runs from the reference clock. Four level inputs control it, each synchronized inside the block: a spread-type strap (centered or downward), a depth select, a modulation enable and an active-high "awake" input whose low level means power-down. The offset is a signed code in units of 0.01 % of the nominal frequency. It follows a triangular sweep whose period is a fixed number of reference cycles.

Each update moves the code by at most one unit, so the DAC never sees a jump. A new depth or spread type requested while the sweep is running waits until the code next passes through zero and is applied there. A settle timer holds the ready flag low after reset, after wake-up and after any change on a control input. While the block is powered down, a gate output tells the clock outputs to stay low.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is asserted, `offset_o` is 0 and `ready_o` and `clk_out_en_o` are low. After reset is released with `awake_i` high, `clk_out_en_o` is high from the 2nd clock edge on. `ready_o` is low up to the (SETTLE_CYCLES+2)th edge and high after the (SETTLE_CYCLES+3)th edge.
- R2: With `spread_center_i`=1 the code is a symmetric triangle. It starts at 0 and rises first. Its peaks are +100/−100 with `depth_sel_i`=1 and +50/−50 with `depth_sel_i`=0, the shallow code being the floor of half the deep one.
- R3: With `spread_center_i`=0 the code never goes above 0. It starts at 0, falls to −200 (`depth_sel_i`=1) or −100 (`depth_sel_i`=0) and returns. The shallow code is minus the floor of half the deep magnitude, so its midpoint is −50.
- R4: Modulation starts with the 3rd clock edge after enable or wake-up. After m running edges the sweep has advanced floor(m·400/PERIOD_CYCLES) steps, and one sweep is 400 steps. With PERIOD_CYCLES=741, the code is 1 after 2 running edges and back at 0 after 741.
- R5: While modulation runs, `offset_o` changes by at most one unit per clock, and it changes only on a step.
- R6: With `mod_en_i` low, `offset_o` is 0 from the 3rd clock edge after the change on.
- R7: With `awake_i` low, `clk_out_en_o` and `ready_o` are low from the 2nd edge on and `offset_o` is 0 from the 3rd. On wake-up, the sweep restarts from 0 under the R4 timing.
- R8: A change on `awake_i`, `mod_en_i`, `depth_sel_i` or `spread_center_i` makes `ready_o` low after the 3rd edge. `ready_o` stays low through the (SETTLE_CYCLES+2)th edge and is high after the (SETTLE_CYCLES+3)th, provided the inputs are unchanged meanwhile.
- R9: A depth or spread-type change made while running takes effect at the first step that finds the code at 0. That step holds the code at 0, and the new profile then runs from its own zero point, rising first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spread_center_i | input | 1 | 1 = centered sweep, 0 = downward sweep (asynchronous) |
| depth_sel_i | input | 1 | 1 = deep sweep, 0 = shallow sweep (asynchronous) |
| mod_en_i | input | 1 | 1 = modulation runs, 0 = code held at 0 (asynchronous) |
| awake_i | input | 1 | 0 = power-down, 1 = operate (asynchronous) |
| offset_o | output | CODE_W | Signed offset code, 0.01 % per unit |
| clk_out_en_o | output | 1 | Low forces both clock outputs low |
| ready_o | output | 1 | High once the settle wait has elapsed |

## Verification
The hardest case to reach is a depth or type change that arrives mid-ramp, because the new setting must wait for a zero crossing that lies hundreds of cycles away. The stimulus toggles the select pins while the code is far from zero. It then tracks every cycle against a model that switches profile exactly one step after the old sweep returns to zero. This is done for a depth change and, separately, for a down-to-center change, whose zero points differ.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;

  typedef enum logic {
    SPREAD_DOWN   = 1'b0,
    SPREAD_CENTER = 1'b1
  } spread_e;

  typedef struct packed {
    spread_e mode;
    logic    deep;
  } ssc_cfg_t;

  // Sweep position at which the code of a given spread type is zero.
  function automatic int ssc_zero(spread_e mode, int depth_hi);
    return (mode == SPREAD_CENTER) ? depth_hi : 0;
  endfunction

  // Offset code for a sweep position 0..2*depth_hi.
  function automatic int ssc_code(int pos, ssc_cfg_t cfg, int depth_hi);
    int rel;
    if (cfg.mode == SPREAD_CENTER) begin
      rel = pos - depth_hi;
      return cfg.deep ? rel : (rel >>> 1);
    end
    return cfg.deep ? -pos : -(pos >>> 1);
  endfunction

endpackage

// File: rtl/ssc_sync.sv
`timescale 1ns/1ps
module ssc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] chg_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      prev_q <= '0;
    end else begin
      pipe_q[0] <= din_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
  assign chg_o  = pipe_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/ssc_settle.sv
`timescale 1ns/1ps
module ssc_settle #(
  parameter int SETTLE_CYCLES = 120000,
  localparam int CW = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic restart_i,
  output logic ready_o
);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= LOAD;
    else if (hold_i || restart_i) cnt_q <= LOAD;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0) && !hold_i;

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !ready_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !ready_o);
endmodule

// File: rtl/ssc_profile.sv
`timescale 1ns/1ps
module ssc_profile import ssc_pkg::*; #(
  parameter int DEPTH_HI      = 100,
  parameter int PERIOD_CYCLES = 741,
  localparam int CODE_W = $clog2(2 * DEPTH_HI) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  input  ssc_cfg_t                 cfg_i,
  output logic signed [CODE_W-1:0] offset_o,
  output logic                     tick_o,
  output logic                     apply_o
);
  localparam int SPAN  = 2 * DEPTH_HI;
  localparam int TICKS = 2 * SPAN;
  localparam int QW    = $clog2(SPAN + 1);
  localparam int AW    = $clog2(PERIOD_CYCLES + TICKS + 1);

  logic [AW-1:0] acc_q, acc_sum;
  logic [QW-1:0] pos_q;
  logic          rising_q;
  ssc_cfg_t      act_q;

  assign acc_sum  = acc_q + AW'(TICKS);
  assign tick_o   = run_i && (acc_sum >= AW'(PERIOD_CYCLES));
  assign offset_o = CODE_W'(ssc_code(int'(pos_q), act_q, DEPTH_HI));
  assign apply_o  = tick_o && (offset_o == '0) && (cfg_i != act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      pos_q    <= '0;
      rising_q <= 1'b1;
      act_q    <= '0;
    end else if (!run_i) begin
      acc_q    <= '0;
      act_q    <= cfg_i;
      pos_q    <= QW'(ssc_zero(cfg_i.mode, DEPTH_HI));
      rising_q <= 1'b1;
    end else begin
      acc_q <= tick_o ? acc_sum - AW'(PERIOD_CYCLES) : acc_sum;
      if (apply_o) begin
        act_q    <= cfg_i;
        pos_q    <= QW'(ssc_zero(cfg_i.mode, DEPTH_HI));
        rising_q <= 1'b1;
      end else if (tick_o) begin
        if (rising_q) begin
          if (pos_q == QW'(SPAN)) begin
            rising_q <= 1'b0;
            pos_q    <= pos_q - 1'b1;
          end else pos_q <= pos_q + 1'b1;
        end else begin
          if (pos_q == '0) begin
            rising_q <= 1'b1;
            pos_q    <= pos_q + 1'b1;
          end else pos_q <= pos_q - 1'b1;
        end
      end
    end
  end

  p_center_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.mode == SPREAD_CENTER) |-> (offset_o >= -DEPTH_HI && offset_o <= DEPTH_HI));
  p_down_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.mode == SPREAD_DOWN) |-> (offset_o <= 0 && offset_o >= -SPAN));
  p_hold_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (offset_o == '0));
  p_defer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && (act_q != $past(act_q))) |-> ($past(offset_o) == '0));
endmodule

// File: rtl/ssc_profile_gen.sv
`timescale 1ns/1ps
module ssc_profile_gen import ssc_pkg::*; #(
  parameter int SYNC_STAGES   = 2,
  parameter int DEPTH_HI      = 100,
  parameter int PERIOD_CYCLES = 741,
  parameter int SETTLE_CYCLES = 120000,
  localparam int CODE_W = $clog2(2 * DEPTH_HI) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     spread_center_i,
  input  logic                     depth_sel_i,
  input  logic                     mod_en_i,
  input  logic                     awake_i,
  output logic signed [CODE_W-1:0] offset_o,
  output logic                     clk_out_en_o,
  output logic                     ready_o
);
  logic [3:0] sync_s, chg_s;
  logic       awake_s, run_s, restart_s, tick_s, apply_s;
  ssc_cfg_t   cfg_s;

  ssc_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  ({spread_center_i, depth_sel_i, mod_en_i, awake_i}),
    .sync_o (sync_s),
    .chg_o  (chg_s)
  );

  assign awake_s    = sync_s[0];
  assign run_s      = sync_s[0] & sync_s[1];
  assign cfg_s.mode = spread_e'(sync_s[3]);
  assign cfg_s.deep = sync_s[2];
  assign restart_s  = |chg_s;

  ssc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (!awake_s),
    .restart_i (restart_s),
    .ready_o   (ready_o)
  );

  ssc_profile #(.DEPTH_HI(DEPTH_HI), .PERIOD_CYCLES(PERIOD_CYCLES)) u_profile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_s),
    .cfg_i    (cfg_s),
    .offset_o (offset_o),
    .tick_o   (tick_s),
    .apply_o  (apply_s)
  );

  assign clk_out_en_o = awake_s;

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_s) |-> (offset_o == $past(offset_o) ||
                       offset_o == $past(offset_o) + CODE_W'(1) ||
                       offset_o == $past(offset_o) - CODE_W'(1)));
  p_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_s) && !$past(tick_s)) |-> $stable(offset_o));
  p_apply_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_s |=> (offset_o == '0));
  p_sleep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_s |=> (offset_o == '0 && !ready_o));
endmodule

// File: tb/ssc_profile_gen_tb.sv
`timescale 1ns/1ps
module ssc_profile_gen_tb_top;
  localparam int S   = 20;
  localparam int PER = 741;
  localparam int TPP = 400;
  localparam int CW  = 9;

  logic clk = 1'b0;
  logic rst_n, center, deep, en, awake;
  logic signed [CW-1:0] offset;
  logic cke, rdy;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  int off_log [0:1499];
  bit rdy_log [0:1499];
  bit cke_log [0:1499];

  always #2.5 clk = ~clk;

  ssc_profile_gen #(.SETTLE_CYCLES(S)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .spread_center_i(center), .depth_sel_i(deep),
    .mod_en_i(en), .awake_i(awake), .offset_o(offset), .clk_out_en_o(cke), .ready_o(rdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(bit c, bit d, int n);
    int p = n % TPP;
    int t;
    if (c) begin
      t = (p <= 100) ? p : ((p <= 300) ? (200 - p) : (p - 400));
      if (d) return t;
      return (t >= 0) ? t / 2 : -((1 - t) / 2);
    end
    t = (p <= 200) ? p : (400 - p);
    return d ? -t : -(t / 2);
  endfunction

  // Runs for 'cycles' samples after a start of modulation; optional mid-run switch.
  task automatic run_profile(input int cycles, input bit c0, input bit d0, input int sw_j,
                             input bit c1, input bit d1, input int apply_n, input string tag,
                             output int mn, output int mx, output int big);
    int bad = 0, fa = 0, fe = 0;
    mn = 0; mx = 0; big = 0;
    for (int j = 1; j <= cycles; j++) begin
      int m, n, e;
      @(negedge clk);
      m = (j < 2) ? 0 : j - 2;
      n = (m * TPP) / PER;
      e = (apply_n > 0 && n >= apply_n) ? exp_code(c1, d1, n - apply_n) : exp_code(c0, d0, n);
      off_log[j] = int'(offset);
      rdy_log[j] = rdy;
      cke_log[j] = cke;
      if (int'(offset) != e && bad == 0) begin fa = int'(offset); fe = e; end
      if (int'(offset) != e) bad++;
      if (int'(offset) < mn) mn = int'(offset);
      if (int'(offset) > mx) mx = int'(offset);
      if (j > 1 && (off_log[j] - off_log[j-1] > 1 || off_log[j-1] - off_log[j] > 1)) big++;
      if (j == sw_j) begin center = c1; deep = d1; end
    end
    chk(bad == 0, tag, fa, fe);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    bit ok_r = 1'b1, ok_k = 1'b1;
    rst_n = 1'b0; awake = 1'b1; en = 1'b0; center = 1'b1; deep = 1'b1;
    idle(4);
    chk(offset == 0 && !rdy && !cke, "R1 reset state", int'({offset != 0, rdy, cke}), 0);
    rst_n = 1'b1;
    for (int j = 1; j <= S + 3; j++) begin
      @(negedge clk);
      if (j == 1 && cke) ok_k = 1'b0;
      if (j >= 2 && !cke) ok_k = 1'b0;
      if (j < S + 3 && rdy) ok_r = 1'b0;
      if (j == S + 3 && !rdy) ok_r = 1'b0;
    end
    chk(ok_k, "R1 clock gate after reset", int'(cke), 1);
    chk(ok_r, "R1 ready timing after reset", int'(rdy), 1);
  endtask

  task automatic t_center_deep;
    int mn, mx, big;
    en = 1'b1;
    run_profile(900, 1, 1, 0, 1, 1, 0, "R2 center deep trace", mn, mx, big);
    chk(mx == 100 && mn == -100, "R2 center deep peaks", mx * 1000 + mn, 100 * 1000 - 100);
    chk(off_log[3] == 0 && off_log[4] == 1, "R4 first step", off_log[4], 1);
    chk(off_log[742] == -1 && off_log[743] == 0, "R4 full period", off_log[743], 0);
    chk(big == 0, "R5 step size center", big, 0);
  endtask

  task automatic t_disable;
    bit ok_o = 1'b1, ok_r = 1'b1;
    int bad_v = 0;
    en = 1'b0;
    for (int j = 1; j <= S + 200; j++) begin
      @(negedge clk);
      if (j >= 3 && offset != 0) begin ok_o = 1'b0; bad_v = int'(offset); end
      if (j >= 3 && j < S + 3 && rdy) ok_r = 1'b0;
      if (j == S + 3 && !rdy) ok_r = 1'b0;
    end
    chk(ok_o, "R6 disabled code zero", bad_v, 0);
    chk(ok_r, "R8 settle after enable change", int'(rdy), 1);
  endtask

  task automatic t_center_shallow;
    int mn, mx, big;
    deep = 1'b0;
    idle(10);
    en = 1'b1;
    run_profile(900, 1, 0, 0, 1, 0, 0, "R2 center shallow trace", mn, mx, big);
    chk(mx == 50 && mn == -50, "R2 center shallow peaks", mx * 1000 + mn, 50 * 1000 - 50);
  endtask

  task automatic t_down;
    int mn, mx, big;
    en = 1'b0; idle(10);
    center = 1'b0; deep = 1'b1; idle(10);
    en = 1'b1;
    run_profile(900, 0, 1, 0, 0, 1, 0, "R3 down deep trace", mn, mx, big);
    chk(mx == 0 && mn == -200, "R3 down deep range", mx * 1000 + mn, -200);
    en = 1'b0; idle(10);
    deep = 1'b0; idle(10);
    en = 1'b1;
    run_profile(900, 0, 0, 0, 0, 0, 0, "R3 down shallow trace", mn, mx, big);
    chk(mx == 0 && mn == -100, "R3 down shallow range", mx * 1000 + mn, -100);
    chk(off_log[2 + (100 * PER + TPP - 1) / TPP] == -50, "R3 shallow midpoint",
        off_log[2 + (100 * PER + TPP - 1) / TPP], -50);
  endtask

  task automatic t_defer_depth;
    int mn, mx, big;
    en = 1'b0; idle(10);
    center = 1'b1; deep = 1'b1; idle(10);
    en = 1'b1;
    run_profile(1100, 1, 1, 50, 1, 0, 201, "R9 depth change at zero", mn, mx, big);
    chk(mx == 100 && mn == -50, "R9 old depth kept until zero", mx * 1000 + mn, 100 * 1000 - 50);
    chk(big == 0, "R5 step size across depth change", big, 0);
  endtask

  task automatic t_defer_mode;
    int mn, mx, big;
    en = 1'b0; idle(10);
    center = 1'b0; deep = 1'b1; idle(10);
    en = 1'b1;
    run_profile(1400, 0, 1, 100, 1, 1, 401, "R9 type change at zero", mn, mx, big);
    chk(mx == 100 && mn == -200, "R9 type change extremes", mx * 1000 + mn, 100 * 1000 - 200);
    chk(big == 0, "R5 step size across type change", big, 0);
  endtask

  task automatic t_powerdown;
    bit ok_d = 1'b1, ok_r = 1'b1;
    int mn, mx, big;
    awake = 1'b0;
    for (int j = 1; j <= 100; j++) begin
      @(negedge clk);
      if (j >= 2 && (cke || rdy)) ok_d = 1'b0;
      if (j >= 3 && offset != 0) ok_d = 1'b0;
    end
    chk(ok_d, "R7 power-down outputs", int'(offset), 0);
    awake = 1'b1;
    run_profile(600, 1, 1, 0, 1, 1, 0, "R7 sweep restarts after wake", mn, mx, big);
    chk(!cke_log[1] && cke_log[2], "R7 clock gate after wake", int'(cke_log[2]), 1);
    for (int j = 1; j <= S + 3; j++) begin
      if (j < S + 3 && rdy_log[j]) ok_r = 1'b0;
      if (j == S + 3 && !rdy_log[j]) ok_r = 1'b0;
    end
    chk(ok_r, "R8 settle after wake", int'(rdy_log[S + 3]), 1);
  endtask

  initial begin
    t_reset();
    t_center_deep();
    t_disable();
    t_center_shallow();
    t_down();
    t_defer_depth();
    t_defer_mode();
    t_powerdown();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule